// File: doc/BRIEF.md
# ULPI Receive Stream Decoder

This block sits on the link side of a ULPI bus and handles only the PHY-to-link direction. It watches the direction, next and 8-bit data lines every clock. It tells the turnaround cycle, the status bytes and the packet bytes apart. It then presents received packet bytes as a simple stream of data, valid and last toward the link logic. The consumer always accepts, so the stream has no ready signal.

Status bytes sent by the PHY (dir high, nxt low) never reach the stream. They update three registered status outputs instead: the two-bit line state, a receive-active flag and a receive-error flag. A status byte may arrive between packet bytes without breaking the packet.

The final byte of a packet is only known when reception ends. For that reason the decoder keeps the newest packet byte in reserve. It releases that byte when the next packet byte arrives. If a status byte reports that reception is inactive, or if dir falls, it releases the byte with last set instead. The asynchronous active-low reset is released to the logic through a short synchronizer.

Top module: `ulpi_rx_decoder`

## Requirements
- R1: While reset is applied, and after it is released, out_valid_o, out_last_o, line_state_o, rx_active_o and rx_error_o are 0, and no packet byte is held in reserve. A byte held when reset arrives is discarded and never emitted.
- R2: The first cycle with dir high after a cycle with dir low is a turnaround. Its data is ignored whatever nxt is: it updates no status output and emits nothing.
- R3: A cycle with dir high (not a turnaround) and nxt low carries a status byte. Its bits 1:0 appear on line_state_o after the next clock edge.
- R4: The rx event field is bits 5:4 of a status byte. 01 means active and sets rx_active_o=1 and rx_error_o=0. 11 means error and sets rx_active_o=1 and rx_error_o=1. Any other value means inactive and clears both flags.
- R5: A status byte whose event is active or error is never emitted as packet data: out_valid_o is 0 after that cycle's edge.
- R6: A packet byte (dir high, nxt high, not a turnaround) is held in reserve. It is emitted with out_last_o=0 on the edge where the next packet byte is sampled.
- R7: A status byte with an inactive event, sampled while a byte is held, emits the held byte with out_last_o=1 on that edge.
- R8: A cycle with dir low, sampled while a byte is held, emits the held byte with out_last_o=1 on that edge.
- R9: The status outputs change only on the edge after a status byte cycle, and otherwise keep their values.
- R10: out_last_o is never 1 while out_valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock of the ULPI interface |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ulpi_dir_i | input | 1 | Bus direction, high when the PHY drives data |
| ulpi_nxt_i | input | 1 | PHY next strobe, high marks a packet byte |
| ulpi_data_i | input | 8 | ULPI data bus as driven by the PHY |
| out_data_o | output | 8 | Emitted packet byte |
| out_valid_o | output | 1 | out_data_o holds a byte this cycle |
| out_last_o | output | 1 | Emitted byte is the last of its packet |
| line_state_o | output | 2 | Line state from the latest status byte |
| rx_active_o | output | 1 | Latest status byte reported active or error |
| rx_error_o | output | 1 | Latest status byte reported error |

## Verification
The assertions check several rules on every cycle: silence after a turnaround, silence after active or error status bytes, the stability of the status outputs between status bytes, the error flag's encoding and last implying valid. Only the bench scenarios can show that bytes come out in order with the one-byte delay. They also show which byte carries last under each of the two end conditions (an inactive status byte and a falling dir). Finally, they show that a reserved byte is lost on reset and that the reserved event code ends a packet.

// File: rtl/ulpi_rx_pkg.sv
package ulpi_rx_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE = 2'd0,
    CYC_TURN = 2'd1,
    CYC_CMD  = 2'd2,
    CYC_DATA = 2'd3
  } cyc_kind_e;

  typedef enum logic [1:0] {
    EV_INACTIVE = 2'b00,
    EV_ACTIVE   = 2'b01,
    EV_RSVD     = 2'b10,
    EV_ERROR    = 2'b11
  } rx_event_e;

endpackage

// File: rtl/ulpi_rx_phase.sv
module ulpi_rx_phase
  import ulpi_rx_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      dir_i,
  input  logic      nxt_i,
  output cyc_kind_e kind_o
);

  logic dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dir_q <= 1'b0;
    else         dir_q <= dir_i;
  end

  always_comb begin
    if (!dir_i)      kind_o = CYC_IDLE;
    else if (!dir_q) kind_o = CYC_TURN;
    else if (nxt_i)  kind_o = CYC_DATA;
    else             kind_o = CYC_CMD;
  end

endmodule

// File: rtl/ulpi_rx_status.sv
module ulpi_rx_status
  import ulpi_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LS_LSB = 0,
  parameter int EV_LSB = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cyc_kind_e         kind_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              end_evt_o,
  output logic [1:0]        line_state_o,
  output logic              rx_active_o,
  output logic              rx_error_o
);

  rx_event_e  ev;
  logic       upd_en;
  logic [1:0] ls_d;
  logic       act_d, err_d;

  always_comb begin
    ev        = rx_event_e'(data_i[EV_LSB +: 2]);
    upd_en    = (kind_i == CYC_CMD);
    ls_d      = data_i[LS_LSB +: 2];
    act_d     = (ev == EV_ACTIVE) || (ev == EV_ERROR);
    err_d     = (ev == EV_ERROR);
    end_evt_o = upd_en && !act_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_state_o <= 2'b00;
      rx_active_o  <= 1'b0;
      rx_error_o   <= 1'b0;
    end else if (upd_en) begin
      line_state_o <= ls_d;
      rx_active_o  <= act_d;
      rx_error_o   <= err_d;
    end
  end

endmodule

// File: rtl/ulpi_rx_hold.sv
module ulpi_rx_hold
  import ulpi_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cyc_kind_e         kind_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              end_evt_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_valid_o,
  output logic              out_last_o
);

  logic [DATA_W-1:0] hold_q;
  logic              hold_vld_q, hold_vld_d;
  logic              hold_en;
  logic              emit_d, last_d;

  always_comb begin
    hold_en    = 1'b0;
    hold_vld_d = hold_vld_q;
    emit_d     = 1'b0;
    last_d     = 1'b0;
    unique case (kind_i)
      CYC_DATA: begin
        emit_d     = hold_vld_q;
        hold_en    = 1'b1;
        hold_vld_d = 1'b1;
      end
      CYC_CMD: begin
        if (end_evt_i && hold_vld_q) begin
          emit_d     = 1'b1;
          last_d     = 1'b1;
          hold_vld_d = 1'b0;
        end
      end
      CYC_IDLE: begin
        if (hold_vld_q) begin
          emit_d     = 1'b1;
          last_d     = 1'b1;
          hold_vld_d = 1'b0;
        end
      end
      default: begin
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hold_q <= '0;
    else if (hold_en) hold_q <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     out_data_o <= '0;
    else if (emit_d) out_data_o <= hold_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_vld_q  <= 1'b0;
      out_valid_o <= 1'b0;
      out_last_o  <= 1'b0;
    end else begin
      hold_vld_q  <= hold_vld_d;
      out_valid_o <= emit_d;
      out_last_o  <= last_d;
    end
  end

endmodule

// File: rtl/ulpi_rx_decoder.sv
module ulpi_rx_decoder
  import ulpi_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int LS_LSB      = 0,
  parameter int EV_LSB      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ulpi_dir_i,
  input  logic              ulpi_nxt_i,
  input  logic [DATA_W-1:0] ulpi_data_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_valid_o,
  output logic              out_last_o,
  output logic [1:0]        line_state_o,
  output logic              rx_active_o,
  output logic              rx_error_o
);

  localparam int SyncMsb = SYNC_STAGES - 1;

  logic [SyncMsb:0] rst_sync_q;
  logic             rst_n_int;
  cyc_kind_e        kind;
  logic             end_evt;

  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rst_sync_q <= 1'b0;
        else         rst_sync_q <= 1'b1;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rst_sync_q <= '0;
        else         rst_sync_q <= {rst_sync_q[SyncMsb-1:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_int = rst_sync_q[SyncMsb];

  ulpi_rx_phase u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .dir_i  (ulpi_dir_i),
    .nxt_i  (ulpi_nxt_i),
    .kind_o (kind)
  );

  ulpi_rx_status #(
    .DATA_W (DATA_W),
    .LS_LSB (LS_LSB),
    .EV_LSB (EV_LSB)
  ) u_status (
    .clk_i        (clk_i),
    .rst_ni       (rst_n_int),
    .kind_i       (kind),
    .data_i       (ulpi_data_i),
    .end_evt_o    (end_evt),
    .line_state_o (line_state_o),
    .rx_active_o  (rx_active_o),
    .rx_error_o   (rx_error_o)
  );

  ulpi_rx_hold #(
    .DATA_W (DATA_W)
  ) u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_int),
    .kind_i      (kind),
    .data_i      (ulpi_data_i),
    .end_evt_i   (end_evt),
    .out_data_o  (out_data_o),
    .out_valid_o (out_valid_o),
    .out_last_o  (out_last_o)
  );

endmodule

// File: rtl/ulpi_rx_decoder_chk.sv
module ulpi_rx_decoder_chk #(
  parameter int DATA_W = 8,
  parameter int EV_LSB = 4
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              dir,
  input logic              nxt,
  input logic [DATA_W-1:0] data,
  input logic              valid,
  input logic              last,
  input logic [1:0]        ls,
  input logic              act,
  input logic              err
);

  AST_TURN_SILENT: assert property (@(posedge clk_i) disable iff (!rst_n)
    (dir && !$past(dir)) |=> (!valid && $stable(ls))); // R2

  AST_CMD_NOT_DATA: assert property (@(posedge clk_i) disable iff (!rst_n)
    (dir && $past(dir) && !nxt && data[EV_LSB]) |=> !valid); // R5

  AST_ERR_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_n)
    (dir && $past(dir) && !nxt && (data[EV_LSB +: 2] == 2'b11)) |=> (err && act)); // R4

  AST_STATUS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(dir && $past(dir) && !nxt) |=> ($stable(ls) && $stable(act) && $stable(err))); // R9

  AST_LAST_VALID: assert property (@(posedge clk_i) disable iff (!rst_n)
    last |-> valid); // R10

endmodule

bind ulpi_rx_decoder ulpi_rx_decoder_chk #(
  .DATA_W (DATA_W),
  .EV_LSB (EV_LSB)
) chk_i (
  .clk_i (clk_i),
  .rst_n (rst_n_int),
  .dir   (ulpi_dir_i),
  .nxt   (ulpi_nxt_i),
  .data  (ulpi_data_i),
  .valid (out_valid_o),
  .last  (out_last_o),
  .ls    (line_state_o),
  .act   (rx_active_o),
  .err   (rx_error_o)
);

// File: tb/ulpi_rx_decoder_tb_top.sv
`timescale 1ns/1ps
module ulpi_rx_decoder_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dir = 1'b0, nxt = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] odata;
  logic       ovalid, olast, oact, oerr;
  logic [1:0] ols;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  ulpi_rx_decoder dut_i (
    .clk_i (clk), .rst_ni (rst_n), .ulpi_dir_i (dir), .ulpi_nxt_i (nxt),
    .ulpi_data_i (din), .out_data_o (odata), .out_valid_o (ovalid),
    .out_last_o (olast), .line_state_o (ols), .rx_active_o (oact),
    .rx_error_o (oerr)
  );

  // {dir, nxt, din[7:0], exp_valid, exp_last, exp_data[7:0], exp_ls[1:0], exp_act, exp_err}
  localparam int NV = 16;
  localparam logic [23:0] VEC [0:NV-1] = '{
    {1'b0,1'b0,8'h00, 1'b0,1'b0,8'h00, 2'd0,1'b0,1'b0}, // idle
    {1'b1,1'b1,8'h00, 1'b0,1'b0,8'h00, 2'd0,1'b0,1'b0}, // R2 turnaround nxt high
    {1'b1,1'b0,8'h12, 1'b0,1'b0,8'h00, 2'd2,1'b1,1'b0}, // R3 R4 active
    {1'b1,1'b1,8'hA5, 1'b0,1'b0,8'h00, 2'd2,1'b1,1'b0}, // R6 held
    {1'b1,1'b1,8'h3C, 1'b1,1'b0,8'hA5, 2'd2,1'b1,1'b0}, // R6 emit
    {1'b1,1'b0,8'h12, 1'b0,1'b0,8'h00, 2'd2,1'b1,1'b0}, // R5 mid cmd
    {1'b1,1'b1,8'h7E, 1'b1,1'b0,8'h3C, 2'd2,1'b1,1'b0}, // R6
    {1'b1,1'b0,8'h02, 1'b1,1'b1,8'h7E, 2'd2,1'b0,1'b0}, // R7 end
    {1'b0,1'b0,8'h00, 1'b0,1'b0,8'h00, 2'd2,1'b0,1'b0}, // R9
    {1'b0,1'b0,8'h00, 1'b0,1'b0,8'h00, 2'd2,1'b0,1'b0},
    {1'b1,1'b0,8'h31, 1'b0,1'b0,8'h00, 2'd2,1'b0,1'b0}, // R2 turnaround cmd
    {1'b1,1'b1,8'h55, 1'b0,1'b0,8'h00, 2'd2,1'b0,1'b0},
    {1'b1,1'b0,8'h31, 1'b0,1'b0,8'h00, 2'd1,1'b1,1'b1}, // R4 error
    {1'b1,1'b1,8'h66, 1'b1,1'b0,8'h55, 2'd1,1'b1,1'b1}, // R6
    {1'b0,1'b0,8'h00, 1'b1,1'b1,8'h66, 2'd1,1'b1,1'b1}, // R8 dir fall
    {1'b0,1'b0,8'h00, 1'b0,1'b0,8'h00, 2'd1,1'b1,1'b1}  // R10
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic d, input logic n, input logic [7:0] b);
    @(negedge clk);
    dir = d; nxt = n; din = b;
    @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    #10;
    chk("R1 valid in reset", {7'd0, ovalid}, 8'd0);
    chk("R1 status in reset", {3'd0, ols, oact, oerr, olast}, 8'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) step(1'b0, 1'b0, 8'h00);
    chk("R1 after release", {3'd0, ols, oact, oerr, ovalid}, 8'd0);

    for (int i = 0; i < NV; i++) begin
      logic [23:0] v;
      v = VEC[i];
      step(v[23], v[22], v[21:14]);
      chk($sformatf("R6 valid vec%0d", i), {7'd0, ovalid}, {7'd0, v[13]});
      chk($sformatf("R10 last vec%0d", i), {7'd0, olast}, {7'd0, v[12]});
      if (v[13]) chk($sformatf("R6 data vec%0d", i), odata, v[11:4]);
      chk($sformatf("R3 R4 R9 status vec%0d", i), {4'd0, ols, oact, oerr}, {4'd0, v[3:0]});
    end

    // R4 R7: reserved event code 10 counts as inactive and ends the packet
    step(1'b1, 1'b0, 8'h00);
    step(1'b1, 1'b1, 8'h77);
    chk("R6 first byte held", {7'd0, ovalid}, 8'd0);
    step(1'b1, 1'b0, 8'h23);
    chk("R7 reserved ends valid", {6'd0, ovalid, olast}, 8'd3);
    chk("R7 reserved ends data", odata, 8'h77);
    chk("R4 reserved flags", {4'd0, ols, oact, oerr}, {4'd0, 2'd3, 1'b0, 1'b0});
    step(1'b1, 1'b0, 8'h10);
    chk("R5 active cmd silent", {7'd0, ovalid}, 8'd0);

    // R1: a held byte is discarded by reset
    step(1'b1, 1'b1, 8'h99);
    @(negedge clk); rst_n = 1'b0; dir = 1'b0; nxt = 1'b0;
    #1;
    chk("R1 async clear", {3'd0, ols, oact, oerr, ovalid}, 8'd0);
    @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < 5; k++) begin
      step(1'b0, 1'b0, 8'h00);
      chk("R1 held byte dropped", {7'd0, ovalid}, 8'd0);
    end

    finish_run();
  end

endmodule